// File: doc/BRIEF.md
# Addressable Bit Latch with Decoder

This block holds an eight-bit word whose bits are written one at a time from a single serial data line. A bit address picks the target bit. Two active-low control lines, a clear line and a write-enable line, together select one of four modes.

- **Write:** stores the data value into the selected bit only.
- **Hold:** freezes every bit.
- **Decode:** turns the block into a one-of-eight decoder. The selected output shows the data value and every other output is low.
- **Clear:** forces every output low.

The storage is a clocked register. Stored bits change on the rising clock edge. The decode and clear outputs are combinational, so they appear in the same cycle as the mode inputs. Both decode and clear also empty the storage at the next edge.

Typical uses are serial-to-parallel loading of control bits, setting single flags at random positions, and driving one-of-eight strobes. A separate asynchronous design reset, `rst_ni`, zeroes the storage independently of the clear line.

Top module: `addr_latch_demux`

## Requirements
- R1: The mode is decoded from {clr_ni, wen_ni}. The value 2'b10 is write, 2'b11 is hold, 2'b00 is decode and 2'b01 is clear.
- R2: In write mode, the bit at index addr_i takes data_i at the rising clock edge. It shows on q_o[addr_i] from the following cycle while the mode is write or hold.
- R3: In write mode, every bit other than the addressed one keeps its stored value across the clock edge.
- R4: In hold mode, q_o shows the stored word, and no bit changes at the clock edge whatever addr_i and data_i carry.
- R5: In decode mode, in the same cycle, q_o[addr_i] equals data_i and all other q_o bits are 0.
- R6: A clock edge in decode mode clears every stored bit, so a following hold cycle reads q_o == 0.
- R7: In clear mode, q_o is 0 in the same cycle, regardless of addr_i and data_i.
- R8: A clock edge in clear mode clears every stored bit, so a following hold cycle reads q_o == 0.
- R9: While rst_ni is low, the stored word is zero without waiting for a clock edge, and q_o reads 0 in hold mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; storage updates on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low design reset of the storage |
| clr_ni | input | 1 | Active-low clear line, first mode select bit |
| wen_ni | input | 1 | Active-low write enable, second mode select bit |
| addr_i | input | 3 | Bit address |
| data_i | input | 1 | Serial data value |
| q_o | output | 8 | Parallel outputs, active high |

## Verification
The assertions assume that the mode, address and data inputs are stable around each rising clock edge, and that the address is never X.

In the level-sensitive form of this function, a multi-bit address change outside hold mode can reach an unintended bit. The random stimulus therefore follows that usage rule: it draws a new address only in cycles that are in hold mode, and keeps the previous address in every other mode.

Directed sequences add decode-then-hold, clear-then-hold and an asynchronous reset in the middle of a run.

// File: rtl/amux_pkg.sv
package amux_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE  = 2'd0,
    MODE_HOLD   = 2'd1,
    MODE_DECODE = 2'd2,
    MODE_CLEAR  = 2'd3
  } mode_e;
endpackage

// File: rtl/amux_mode_dec.sv
module amux_mode_dec
  import amux_pkg::*;
(
  input  logic  clr_ni,
  input  logic  wen_ni,
  output mode_e mode_o
);
  always_comb begin
    unique case ({clr_ni, wen_ni})
      2'b10:   mode_o = MODE_WRITE;
      2'b11:   mode_o = MODE_HOLD;
      2'b00:   mode_o = MODE_DECODE;
      default: mode_o = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/amux_addr_dec.sv
module amux_addr_dec #(
  parameter int NUM_BITS = 8,
  localparam int ADDR_W  = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_BITS-1:0] sel_o
);
  for (genvar g = 0; g < NUM_BITS; g++) begin : g_sel
    assign sel_o[g] = (addr_i == ADDR_W'(g));
  end
endmodule

// File: rtl/amux_store.sv
module amux_store
  import amux_pkg::*;
#(
  parameter int NUM_BITS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  mode_e               mode_i,
  input  logic [NUM_BITS-1:0] sel_i,
  input  logic                data_i,
  output logic [NUM_BITS-1:0] bits_o
);
  for (genvar g = 0; g < NUM_BITS; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bits_o[g] <= 1'b0;
      end else begin
        unique case (mode_i)
          MODE_WRITE:  if (sel_i[g]) bits_o[g] <= data_i;
          MODE_DECODE,
          MODE_CLEAR:  bits_o[g] <= 1'b0;
          default:     bits_o[g] <= bits_o[g];
        endcase
      end
    end
  end
endmodule

// File: rtl/amux_out_sel.sv
module amux_out_sel
  import amux_pkg::*;
#(
  parameter int NUM_BITS = 8
) (
  input  mode_e               mode_i,
  input  logic [NUM_BITS-1:0] sel_i,
  input  logic                data_i,
  input  logic [NUM_BITS-1:0] bits_i,
  output logic [NUM_BITS-1:0] q_o
);
  always_comb begin
    unique case (mode_i)
      MODE_DECODE: q_o = sel_i & {NUM_BITS{data_i}};
      MODE_CLEAR:  q_o = '0;
      default:     q_o = bits_i;
    endcase
  end
endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux
  import amux_pkg::*;
#(
  parameter int NUM_BITS = 8,
  localparam int ADDR_W  = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_ni,
  input  logic                wen_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                data_i,
  output logic [NUM_BITS-1:0] q_o
);
  mode_e               mode;
  logic [NUM_BITS-1:0] sel;
  logic [NUM_BITS-1:0] bits;

  amux_mode_dec u_mode (
    .clr_ni (clr_ni),
    .wen_ni (wen_ni),
    .mode_o (mode)
  );

  amux_addr_dec #(.NUM_BITS(NUM_BITS)) u_adec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  amux_store #(.NUM_BITS(NUM_BITS)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .sel_i  (sel),
    .data_i (data_i),
    .bits_o (bits)
  );

  amux_out_sel #(.NUM_BITS(NUM_BITS)) u_out (
    .mode_i (mode),
    .sel_i  (sel),
    .data_i (data_i),
    .bits_i (bits),
    .q_o    (q_o)
  );
endmodule

// File: rtl/amux_checker.sv
module amux_checker #(
  parameter int NUM_BITS = 8,
  localparam int ADDR_W  = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                clr_ni,
  input logic                wen_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                data_i,
  input logic [NUM_BITS-1:0] q_o
);
  logic is_wr, is_hold, is_dec, is_clr;
  assign is_wr   =  clr_ni && !wen_ni;
  assign is_hold =  clr_ni &&  wen_ni;
  assign is_dec  = !clr_ni && !wen_ni;
  assign is_clr  = !clr_ni &&  wen_ni;

  assert_write_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_wr |=> (clr_ni -> (q_o[$past(addr_i)] == $past(data_i))));

  assert_write_others_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_wr |=> (clr_ni ->
      (((q_o ^ $past(q_o)) & ~(NUM_BITS'(1) << $past(addr_i))) == '0)));

  assert_hold_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_hold |=> (is_hold -> $stable(q_o)));

  assert_decode_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_dec |-> ($onehot0(q_o) && (q_o[addr_i] == data_i)));

  assert_decode_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_dec |=> (clr_ni -> (q_o == '0)));

  assert_clear_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_clr |-> (q_o == '0));

  assert_clear_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_clr |=> (is_hold -> (q_o == '0)));
endmodule

bind addr_latch_demux amux_checker #(.NUM_BITS(NUM_BITS)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clr_ni (clr_ni),
  .wen_ni (wen_ni),
  .addr_i (addr_i),
  .data_i (data_i),
  .q_o    (q_o)
);

// File: tb/addr_latch_demux_test.sv
`timescale 1ns/1ps
module addr_latch_demux_test;
  localparam int NB = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr_n = 1'b1;
  logic          wen_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          din = 1'b0;
  logic [NB-1:0] q;

  int total = 0;
  int bad = 0;
  logic [NB-1:0] model = '0;

  always #4 clk = ~clk;

  addr_latch_demux uut (
    .clk_i (clk), .rst_ni (rst_n), .clr_ni (clr_n), .wen_ni (wen_n),
    .addr_i (addr), .data_i (din), .q_o (q)
  );

  // R1: 10 write, 11 hold, 00 decode, 01 clear
  function automatic logic [NB-1:0] exp_q(logic c, logic w, logic [AW-1:0] a,
                                          logic d, logic [NB-1:0] st);
    if (!c && !w) return d ? (NB'(1) << a) : '0;
    if (!c && w)  return '0;
    return st;
  endfunction

  function automatic logic [NB-1:0] next_st(logic c, logic w, logic [AW-1:0] a,
                                            logic d, logic [NB-1:0] st);
    logic [NB-1:0] r;
    r = st;
    if (c && !w) r[a] = d;
    else if (!c) r = '0;
    return r;
  endfunction

  task automatic check(string req, logic [NB-1:0] act, logic [NB-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: q=%b expected %b", req, act, exp);
    end
  endtask

  function automatic string tag_of(logic c, logic w);
    if (c && !w) return "R1 R2 R3 write";
    if (c && w)  return "R1 R4 hold";
    if (!c && !w) return "R1 R5 decode";
    return "R1 R7 clear";
  endfunction

  // drive at negedge, check 1 ns before the rising edge, then advance model
  task automatic step(logic c, logic w, logic [AW-1:0] a, logic d, string req);
    @(negedge clk);
    clr_n = c; wen_n = w; addr = a; din = d;
    #3;
    check(req, q, exp_q(c, w, a, d, model));
    @(posedge clk);
    model = next_st(c, w, a, d, model);
  endtask

  initial begin
    #(8ns * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: q=%b expected completion", q);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] cur_a;
    void'($urandom(32'd2718));
    #1;
    check("R9 reset", q, '0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R3: serial load of a pattern, then hold readback
    for (int i = 0; i < NB; i++) step(1'b1, 1'b0, AW'(i), 1'(i % 3 == 0), "R2 R3 load");
    step(1'b1, 1'b1, 3'd5, 1'b1, "R4 hold after load");
    // R3: overwrite one bit only
    step(1'b1, 1'b0, 3'd1, 1'b1, "R2 R3 single");
    step(1'b1, 1'b1, 3'd7, 1'b0, "R2 R3 readback");
    // R4: hold ignores address and data
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, AW'(i * 2 + 1), 1'(i), "R4 ignore");
    // R5: decode each address with data 1 and 0
    for (int i = 0; i < NB; i++) step(1'b0, 1'b0, AW'(i), 1'b1, "R5 decode one");
    step(1'b0, 1'b0, 3'd4, 1'b0, "R5 decode zero");
    // R6: decode empties storage
    step(1'b1, 1'b1, 3'd4, 1'b1, "R6 after decode");
    check("R6 model empty", model, '0);
    // R7 R8
    for (int i = 0; i < NB; i++) step(1'b1, 1'b0, AW'(i), 1'b1, "R2 fill");
    step(1'b1, 1'b1, 3'd0, 1'b0, "R4 full");
    step(1'b0, 1'b1, 3'd6, 1'b1, "R7 clear");
    step(1'b1, 1'b1, 3'd6, 1'b1, "R8 after clear");
    // R9: async reset mid-run
    for (int i = 0; i < NB; i++) step(1'b1, 1'b0, AW'(i), 1'b1, "R2 refill");
    @(negedge clk);
    clr_n = 1'b1; wen_n = 1'b1;
    #1 rst_n = 1'b0;
    #1 check("R9 async", q, '0);
    model = '0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b1, 3'd2, 1'b1, "R9 after release");

    // random, address changes only in hold
    cur_a = '0;
    for (int i = 0; i < 600; i++) begin
      logic [1:0] m;
      logic c, w, d;
      m = 2'($urandom_range(0, 3));
      c = m[1]; w = m[0];
      if (c && w) cur_a = AW'($urandom_range(0, NB - 1));
      d = 1'($urandom_range(0, 1));
      step(c, w, cur_a, d, tag_of(c, w));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule